// File: doc/BRIEF.md
# Multiplexed LED Grid Scanner with Dimming

This block drives a common-cathode LED panel from a 14-byte display RAM. It lights one grid (digit common) at a time and, while that grid is lit, drives the segment lines with the pattern stored for that digit. A mode input selects how many grids are scanned: 4, 5, 6 or 7. Three output pins are shared between roles. In modes with fewer grids they are extra segment lines, and in modes with more grids they become grid lines. A 3-bit dimming level sets how much of each grid slot is lit. A display-on flag blanks everything when it is low.

Time comes from a clock-enable prescaler. One tick lasts `TICK_DIV` clocks, and every grid slot is sixteen ticks long. Tick 0 of each slot is always dark. This gives a guard interval at each grid change, and the block uses it to fetch the two RAM bytes of the next digit through its single asynchronous read port. Ticks 1 to level+1 are lit and the rest of the slot is dark.

Top module: `led_grid_scanner`

## Requirements
- R1: While reset is asserted, and in the first clock after it is released, every segment, shared and grid output is low.
- R2: While `dispOn` is low, every segment, shared and grid output stays low.
- R3: Grids are lit in ascending order from grid 1 to the last active grid, then the scan wraps to grid 1. The last grid is grid 4, 5, 6 or 7 for `modeSel` 0, 1, 2 or 3.
- R4: At most one grid is lit at any time, and segment lines are only high while a grid is lit.
- R5: For grid n, segments 1 to 8 show bits 0 to 7 of RAM byte 2(n-1), with bit 0 on segment 1. Segments 9 to 12 show bits 0 to 3 of byte 2(n-1)+1, and bits 7:4 of that byte have no effect.
- R6: `dualOut[2]` is segment 12 in mode 0 and grid 5 otherwise. `dualOut[1]` is segment 11 in modes 0 and 1 and grid 6 otherwise. `dualOut[0]` is segment 10 in modes 0 to 2 and grid 7 in mode 3. A pin in its grid role never carries segment data.
- R7: In each slot of 16 ticks, a grid is lit for exactly (dimLevel+1) ticks, that is (dimLevel+1)·TICK_DIV clocks. The first tick of every slot is dark.
- R8: A change of `modeSel` restarts the scan at grid 1 within one clock, and the next grid lit is grid 1.
- R9: Each grid slot lasts 16·TICK_DIV clocks, so successive grids first light 16·TICK_DIV clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 2 | Grid count select: 0..3 gives 4..7 grids |
| dispOn | input | 1 | Display enable |
| dimLevel | input | 3 | Brightness step, 0 dimmest to 7 brightest |
| ramAddr | output | 4 | Display RAM read address |
| ramData | input | 8 | Display RAM read data, valid in the same cycle as ramAddr |
| segOut | output | 9 | Segments 1..9, active-high |
| dualOut | output | 3 | Shared pins: [0] seg10/grid7, [1] seg11/grid6, [2] seg12/grid5, active-high |
| gridOut | output | 4 | Grids 1..4, active-high |

## Verification
The bench builds the block with `TICK_DIV` = 4, so one slot is 64 clocks and a full 7-grid frame is 448 clocks. This keeps several complete frames for every mode and several dimming levels well within the cycle budget. With this small divider, exact per-grid lit-clock counts, the 64-clock spacing between grids and the restart on a mode change can all be measured directly at the ports.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;
  localparam int MODE_W    = 2;
  localparam int GRID_W    = 3;
  localparam int MAX_GRIDS = 7;
  localparam int BASE_GRID = 4;   // grids scanned in mode 0
  localparam int SEG_MAIN  = 9;   // dedicated segment pins
  localparam int SHARED    = 3;   // pins that switch role
  localparam int SEG_TOTAL = SEG_MAIN + SHARED;
  localparam int ADDR_W    = GRID_W + 1;
  localparam int BYTE_W    = 8;

  typedef struct packed {
    logic              fetchLo;  // latch low byte of digit
    logic              fetchHi;  // latch high nibble of digit
    logic              lit;      // drive outputs this cycle
    logic [GRID_W-1:0] grid;     // zero-based grid index
    logic [MODE_W-1:0] mode;     // mode in effect
  } scan_ctl_t;
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import led_scan_pkg::*;
#(
  parameter int TICK_DIV = 64,
  parameter int DIM_BITS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeSel,
  input  logic              dispOn,
  input  logic [DIM_BITS-1:0] dimLevel,
  output logic [ADDR_W-1:0] ramAddr,
  output scan_ctl_t         ctl
);
  localparam int TICK_W     = DIM_BITS + 1;
  localparam int SLOT_TICKS = 2 ** TICK_W;
  localparam int DIV_W      = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(TICK_DIV - 1);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(SLOT_TICKS - 1);

  logic [DIV_W-1:0]  divCnt;
  logic [TICK_W-1:0] tickCnt;
  logic [GRID_W-1:0] gridIdx;
  logic [MODE_W-1:0] modeReg;
  logic [GRID_W-1:0] lastGrid;
  logic              tickEn;
  logic              modeChange;
  logic              inWindow;

  assign lastGrid   = GRID_W'(BASE_GRID - 1) + GRID_W'(modeReg);
  assign tickEn     = (divCnt == DIV_LAST);
  assign modeChange = (modeSel != modeReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt  <= '0;
      tickCnt <= '0;
      gridIdx <= '0;
      modeReg <= '1;
    end else if (modeChange) begin
      modeReg <= modeSel;
      divCnt  <= '0;
      tickCnt <= '0;
      gridIdx <= '0;
    end else if (tickEn) begin
      divCnt  <= '0;
      tickCnt <= tickCnt + 1'b1;
      if (tickCnt == TICK_LAST)
        gridIdx <= (gridIdx == lastGrid) ? '0 : gridIdx + 1'b1;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign inWindow = (tickCnt != '0) &&
                    ((tickCnt - 1'b1) <= {1'b0, dimLevel});

  always_comb begin
    ctl         = '0;
    ctl.fetchLo = (tickCnt == '0) && (divCnt == DIV_W'(0));
    ctl.fetchHi = (tickCnt == '0) && (divCnt == DIV_W'(1));
    ctl.lit     = dispOn && inWindow && rstN;
    ctl.grid    = gridIdx;
    ctl.mode    = modeReg;
  end

  assign ramAddr = {gridIdx, ctl.fetchHi};

  a_r3_grid_in_range: assert property (@(posedge clk) disable iff (!rstN)
    gridIdx <= lastGrid);
  a_r8_mode_restart: assert property (@(posedge clk) disable iff (!rstN)
    modeChange |=> (gridIdx == '0 && tickCnt == '0));
  a_r7_guard_dark: assert property (@(posedge clk) disable iff (!rstN)
    (tickCnt == '0) |-> !ctl.lit);
  a_r2_off_dark: assert property (@(posedge clk) disable iff (!rstN)
    !dispOn |-> !ctl.lit);
  a_r9_tick_step: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !modeChange) |=> (tickCnt == $past(tickCnt) + 1'b1));
endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import led_scan_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  scan_ctl_t         ctl,
  input  logic [BYTE_W-1:0] ramData,
  output logic [SEG_MAIN-1:0] segOut,
  output logic [SHARED-1:0] dualOut,
  output logic [BASE_GRID-1:0] gridOut
);
  logic [SEG_TOTAL-1:0] segLatch;
  logic [MAX_GRIDS-1:0] gridVec;
  logic [SHARED-1:0]    dualGridRole;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      segLatch <= '0;
    end else begin
      if (ctl.fetchLo) segLatch[BYTE_W-1:0] <= ramData;
      if (ctl.fetchHi) segLatch[SEG_TOTAL-1:BYTE_W] <= ramData[SEG_TOTAL-BYTE_W-1:0];
    end
  end

  always_comb begin
    gridVec = '0;
    if (ctl.lit) gridVec[ctl.grid] = 1'b1;
  end

  assign gridOut = gridVec[BASE_GRID-1:0];
  assign segOut  = ctl.lit ? segLatch[SEG_MAIN-1:0] : '0;

  // Shared pin k: segment (SEG_MAIN+1+k) or grid (MAX_GRIDS-k);
  // it becomes a grid once the mode reaches SHARED-k.
  for (genvar k = 0; k < SHARED; k++) begin : g_shared
    localparam logic [MODE_W-1:0] GRID_MODE = MODE_W'(SHARED - k);
    always_comb begin
      dualGridRole[k] = (ctl.mode >= GRID_MODE);
      dualOut[k] = dualGridRole[k] ? gridVec[MAX_GRIDS-1-k]
                                   : (ctl.lit & segLatch[SEG_MAIN+k]);
    end
  end

  a_r4_one_grid: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({gridOut, dualOut & dualGridRole}));
  a_r4_seg_needs_grid: assert property (@(posedge clk) disable iff (!rstN)
    (|{segOut, dualOut & ~dualGridRole}) |-> (|{gridOut, dualOut & dualGridRole}));
  a_r5_hi_latch: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fetchLo |=> $stable(segLatch[SEG_TOTAL-1:BYTE_W]));
endmodule

// File: rtl/led_grid_scanner.sv
module led_grid_scanner
  import led_scan_pkg::*;
#(
  parameter int TICK_DIV = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       dispOn,
  input  logic [2:0] dimLevel,
  output logic [3:0] ramAddr,
  input  logic [7:0] ramData,
  output logic [8:0] segOut,
  output logic [2:0] dualOut,
  output logic [3:0] gridOut
);
  scan_ctl_t ctl;

  scan_ctrl #(.TICK_DIV(TICK_DIV), .DIM_BITS(3)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .dispOn(dispOn),
    .dimLevel(dimLevel), .ramAddr(ramAddr), .ctl(ctl)
  );

  scan_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .ramData(ramData),
    .segOut(segOut), .dualOut(dualOut), .gridOut(gridOut)
  );
endmodule

// File: tb/led_grid_scanner_test.sv
`timescale 1ns/1ps
module led_grid_scanner_test;
  localparam int DIV  = 4;
  localparam int SLOT = 16 * DIV;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] modeSel = 2'd3;
  logic dispOn = 1'b1;
  logic [2:0] dimLevel = 3'd7;
  logic [3:0] ramAddr;
  logic [7:0] ramData;
  logic [8:0] segOut;
  logic [2:0] dualOut;
  logic [3:0] gridOut;
  logic [7:0] ram [14];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign ramData = (ramAddr < 4'd14) ? ram[ramAddr] : 8'h00;

  led_grid_scanner #(.TICK_DIV(DIV)) uut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .dispOn(dispOn),
    .dimLevel(dimLevel), .ramAddr(ramAddr), .ramData(ramData),
    .segOut(segOut), .dualOut(dualOut), .gridOut(gridOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] gridsSeen(input int mode);
    logic [6:0] g;
    g = {3'b000, gridOut};
    if (mode >= 1) g[4] = dualOut[2];
    if (mode >= 2) g[5] = dualOut[1];
    if (mode == 3) g[6] = dualOut[0];
    return g;
  endfunction

  task automatic setMode(input int m);
    @(negedge clk) modeSel = 2'(m ^ 1);
    @(negedge clk) modeSel = 2'(m);
    @(posedge clk);
  endtask

  // Observe whole frames; any integer number of frames gives exact counts.
  task automatic observe(input int mode, input int level, input int frames, input string tag);
    int nG = 4 + mode;
    int onCnt[7];
    int prevG = -1;
    int badOne = 0, badOrd = 0, badSeg = 0, badRole = 0, badCnt = 0;
    int actV = 0, expV = 0;
    for (int i = 0; i < 7; i++) onCnt[i] = 0;
    for (int c = 0; c < frames * nG * SLOT; c++) begin
      logic [6:0] g;
      @(negedge clk);
      g = gridsSeen(mode);
      if ($countones(g) > 1) badOne++;
      if (g == 0) begin
        logic [2:0] segRoleMask;
        segRoleMask = 3'b000;
        for (int k = 0; k < 3; k++) if (mode < 3 - k) segRoleMask[k] = 1'b1;
        if (segOut != 0 || (dualOut & segRoleMask) != 0) badOne++;
      end else begin
        int gi = 0;
        logic [11:0] exp12;
        for (int i = 0; i < 7; i++) if (g[i]) gi = i;
        onCnt[gi]++;
        if (gi != prevG) begin
          if (prevG >= 0 && gi != (prevG + 1) % nG) begin badOrd++; actV = gi; expV = (prevG+1)%nG; end
          prevG = gi;
        end
        exp12 = {ram[2*gi+1][3:0], ram[2*gi]};
        if (segOut != exp12[8:0]) badSeg++;
        for (int k = 0; k < 3; k++) begin
          if (mode >= 3 - k) begin
            if (dualOut[k] != (gi == 6 - k)) badRole++;
          end else if (dualOut[k] != exp12[9+k]) badRole++;
        end
      end
    end
    for (int i = 0; i < 7; i++) begin
      int e = (i < nG) ? frames * (level + 1) * DIV : 0;
      if (onCnt[i] != e && badCnt == 0) begin badCnt++; actV = onCnt[i]; expV = e; end
    end
    check(badOne == 0, {"R4 ", tag}, badOne, 0);
    check(badOrd == 0, {"R3 ", tag}, actV, expV);
    check(badSeg == 0, {"R5 ", tag}, badSeg, 0);
    check(badRole == 0, {"R6 ", tag}, badRole, 0);
    check(badCnt == 0, {"R7 ", tag}, actV, expV);
  endtask

  task automatic testReset();
    @(negedge clk);
    check({segOut, dualOut, gridOut} == 0, "R1 in reset", {segOut, dualOut, gridOut}, 0);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    check({segOut, dualOut, gridOut} == 0, "R1 after release", {segOut, dualOut, gridOut}, 0);
  endtask

  task automatic testScan(input int mode, input int level);
    @(negedge clk) dimLevel = 3'(level);
    setMode(mode);
    observe(mode, level, 2, $sformatf("mode%0d lvl%0d", mode, level));
  endtask

  task automatic testOff();
    int lit = 0;
    @(negedge clk) dispOn = 1'b0;
    for (int c = 0; c < 7 * SLOT; c++) begin
      @(negedge clk);
      if ({segOut, dualOut, gridOut} != 0) lit++;
    end
    check(lit == 0, "R2 display off", lit, 0);
    @(negedge clk) dispOn = 1'b1;
  endtask

  task automatic testRestart();
    int first = -1, second = -1, firstG = -1, secondG = -1;
    @(negedge clk) dimLevel = 3'd2;
    setMode(3);
    repeat (4 * SLOT + 20) @(negedge clk);   // now inside grid 5
    modeSel = 2'd0;
    for (int c = 0; c < 3 * SLOT; c++) begin
      logic [6:0] g;
      @(negedge clk);
      g = gridsSeen(0);
      if (g != 0) begin
        int gi = 0;
        for (int i = 0; i < 7; i++) if (g[i]) gi = i;
        if (first < 0) begin first = c; firstG = gi; end
        else if (second < 0 && gi != firstG) begin second = c; secondG = gi; end
      end
    end
    check(firstG == 0 && first >= 0 && first < 10, "R8 restart at grid 1", firstG, 0);
    check(secondG == 1 && second - first == SLOT, "R9 slot spacing", second - first, SLOT);
  endtask

  initial begin
    for (int i = 0; i < 14; i++) ram[i] = 8'((i * 37 + 5) ^ (i * 16));
    ram[1] = 8'hF5;
    testReset();
    testScan(0, 7);
    testScan(1, 0);
    testScan(2, 3);
    testScan(3, 5);
    testOff();
    testRestart();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule